// File: doc/BRIEF.md
# Multicycle Fixed-Field Instruction Processor

This block is a small processor core. It runs 32-bit instructions whose fields sit at fixed bit positions. Each instruction passes through six phases, one after the other: fetch, program-counter step, decode, operand fetch, execute and store. It then fetches again. Instructions and data share one memory port, which is word addressed, 32 bits wide and paced by a ready handshake. The core holds sixteen 32-bit general registers, a 16-bit program counter, a 16-bit stack pointer for subroutine linkage, two condition flags and a sticky divide-error flag.

Every instruction has the same layout. It carries an opcode, an operand size, four mode bits and a register number. Its low 16 bits serve as an address, an immediate value or a second register number, depending on the mode bits. An instruction touches at most one data location. A read-modify-write of that location counts as one reference. Halt and illegal encodings stop the core. A trap instruction is reported to the surrounding logic as a one-cycle pulse that carries a code, and the core then continues.

Top module: `fixfmt_cpu`

## Requirements
- R1: While rst_n is low at a clock edge the core returns to the fetch phase with PC = 0 and stack pointer = 0xFFFF. The outputs halted, illegal, trap_pulse, div_err, flag_zero and flag_neg are all 0, and the first fetch reads address 0.
- R2: PC rises by exactly 1 in a phase of its own that directly follows the fetch. Every later phase of the same instruction sees the address of the next instruction. A subroutine call therefore saves the address of the instruction that follows the call.
- R3: A memory request (mem_rd or mem_wr, together with mem_addr and mem_wdata) stays unchanged until mem_ready is sampled high. mem_rd and mem_wr are never high together.
- R4: Field layout: opcode [31:28], size [27:24], indirect [23], immediate [22], direction [21], memory operand [20], register [19:16], low field [15:0]. The source operand is chosen as follows:
  - When bit 22 is set, the source is the zero-extended low field, and bit 20 is ignored.
  - Otherwise, when bit 20 is set, the source is memory. Its address is the low field when bit 23 is clear. When bit 23 is set, the address is the low 16 bits of the register numbered by field bits [3:0].
  - Otherwise, the source is the register numbered by field bits [3:0].
- R5: With bit 21 = 0 the register named in [19:16] is the destination and the other operand is the source. With bit 21 = 1 the roles swap: the memory word or the second register becomes the destination. An immediate operand (bit 22) combined with bit 21 = 1 is illegal.
- R6: Size codes are 0 = 8 bits, 1 = 16 bits and 2 = 32 bits. Both operands are cut to the size, and the result is zero-extended when written. Any other size code sets illegal and halts the core, and no further memory access follows.
- R7: Opcodes 1 (copy) and 8 to 15 compute destination := f(destination, source). The functions are:
  - copy: source
  - add
  - sub: destination − source
  - mult: low bits of the product
  - and
  - or
  - not: bitwise complement of the source
  - rotate: rotate destination left by source modulo the size width
- R8: Opcode 11 (divide) writes the unsigned quotient. A zero divisor writes all ones within the size and sets div_err, which stays set until reset.
- R9: Opcode 5 (compare) sets flag_zero and flag_neg from destination − source at the given size, using the size's top bit as the sign. It writes neither a register nor memory.
- R10: Opcode 2 (load address) writes the effective address (direct or indirect) to the register in [19:16], zero-extended, and makes no data access.
- R11: Opcode 4 jumps to the low field. Opcode 6 decrements the stack pointer, writes the return PC at the new stack pointer, then jumps to the low field. Opcode 7 reads the PC from the stack pointer and increments the stack pointer.
- R12: Opcode 3 (trap) raises trap_pulse for exactly one cycle with trap_code equal to the low field, then goes on with the next instruction.
- R13: Opcode 0 (halt) holds halted high until reset, and the core makes no further memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Word address of the current request |
| mem_wdata | output | 32 | Data to write |
| mem_rdata | input | 32 | Data read, valid when mem_ready is high |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_ready | input | 1 | Request completes at this edge |
| halted | output | 1 | Core stopped (halt or illegal instruction) |
| illegal | output | 1 | An illegal encoding was decoded |
| trap_pulse | output | 1 | One-cycle trap indication |
| trap_code | output | 16 | Low field of the last trap |
| div_err | output | 1 | Sticky divide-by-zero indication |
| flag_zero | output | 1 | Last compare result was zero |
| flag_neg | output | 1 | Last compare result was negative |

## Verification
An instruction that uses no memory takes six cycles after its fetch is accepted. A result written to memory is presented in the store phase: five cycles after the fetch handshake when no operand is read, and later by the operand-read latency when one is. A register result becomes visible only through a later store instruction. Compare flags and the divide-error flag are updated in the execute phase, so they are already settled when any later store is presented. The trap pulse appears in the cycle after the trap's execute phase.

The bench answers every request after 0, 1 or 2 wait cycles, in rotation. It compares each write against the scoreboard at the moment the write is granted, and the expected flags travel with each expected write. Because checks follow the handshake rather than fixed cycle counts, a result that arrives early, late or with wrong data is still reported.

// File: rtl/fixfmt_pkg.sv
// Shared types for the fixed-field processor: opcodes, sizes, phases,
// the instruction layout and the decoded control word.
package fixfmt_pkg;

    typedef enum logic [3:0] {
        OP_HALT = 4'd0,  OP_COPY = 4'd1,  OP_LEA  = 4'd2,  OP_TRAP = 4'd3,
        OP_JMP  = 4'd4,  OP_CMP  = 4'd5,  OP_JSR  = 4'd6,  OP_RET  = 4'd7,
        OP_ADD  = 4'd8,  OP_SUB  = 4'd9,  OP_MUL  = 4'd10, OP_DIV  = 4'd11,
        OP_AND  = 4'd12, OP_OR   = 4'd13, OP_NOT  = 4'd14, OP_ROT  = 4'd15
    } opcode_e;

    typedef enum logic [1:0] {SZ_BYTE, SZ_WORD, SZ_LONG, SZ_BAD} size_e;

    typedef enum logic [2:0] {
        PH_FETCH, PH_PCUP, PH_DECODE, PH_OPER, PH_EXEC, PH_STORE, PH_HALT
    } phase_e;

    typedef struct packed {
        opcode_e     op;
        logic [3:0]  size;
        logic        ind;
        logic        imm;
        logic        dir;
        logic        mem;
        logic [3:0]  rsel;
        logic [15:0] fld;
    } instr_t;

    typedef struct packed {
        logic       illegal;
        size_e      sz;
        logic       src_mem;
        logic       mem_read;
        logic       mem_write;
        logic       reg_write;
        logic [3:0] wsel;
    } ctrl_t;

endpackage

// File: rtl/fixfmt_decode.sv
// Decoder: turns the opcode, size and mode fields into a control word.
// Assumes the instruction register is stable while its outputs are used.
module fixfmt_decode
    import fixfmt_pkg::*;
(
    input  opcode_e    op,
    input  logic [3:0] size_code,
    input  logic       imm,
    input  logic       dir,
    input  logic       mem,
    input  logic [3:0] rsel,
    input  logic [3:0] lo_reg,
    output ctrl_t      ctl
);

    logic is_data;
    logic overwrite_only;

    // Classify the opcode and derive every control bit.
    always_comb begin
        is_data        = (op == OP_COPY) || (op == OP_CMP) || op[3];
        overwrite_only = (op == OP_COPY) || (op == OP_NOT);
        unique case (size_code)
            4'd0:    ctl.sz = SZ_BYTE;
            4'd1:    ctl.sz = SZ_WORD;
            4'd2:    ctl.sz = SZ_LONG;
            default: ctl.sz = SZ_BAD;
        endcase
        ctl.illegal   = (ctl.sz == SZ_BAD) || (is_data && imm && dir);
        ctl.src_mem   = is_data && !imm && mem;
        ctl.mem_read  = (ctl.src_mem && !(dir && overwrite_only)) || (op == OP_RET);
        ctl.mem_write = (ctl.src_mem && dir && (op != OP_CMP)) || (op == OP_JSR);
        ctl.reg_write = (is_data && (op != OP_CMP) && !(dir && ctl.src_mem))
                        || (op == OP_LEA);
        ctl.wsel      = (is_data && dir) ? lo_reg : rsel;
    end

endmodule

// File: rtl/fixfmt_regfile.sv
// General register file: two combinational read ports, one write port.
// Assumes a single writer; all entries clear on reset.
module fixfmt_regfile #(
    parameter int NREG   = 16,
    parameter int DATA_W = 32,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  ra0,
    input  logic [SEL_W-1:0]  ra1,
    output logic [DATA_W-1:0] rd0,
    output logic [DATA_W-1:0] rd1,
    input  logic              we,
    input  logic [SEL_W-1:0]  wa,
    input  logic [DATA_W-1:0] wd
);

    logic [DATA_W-1:0] regs [NREG];

    // Read ports, no bypass.
    assign rd0 = regs[ra0];
    assign rd1 = regs[ra1];

    // One storage process per entry: clear on reset, load on a matching write.
    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && (wa == SEL_W'(g)))
                regs[g] <= wd;
        end
    end

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(wa)] == $past(wd)));

endmodule

// File: rtl/fixfmt_alu.sv
// Sized arithmetic and logic unit: computes dest op src at 8, 16 or full
// width, zero-extends the result and reports compare flags and a zero divisor.
module fixfmt_alu
    import fixfmt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  opcode_e           op,
    input  size_e             sz,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              zero,
    output logic              neg,
    output logic              div0
);

    logic [DATA_W-1:0] mask, sign_bit, am, bm, diff, rot;
    int unsigned       width, sh;

    // Mask and width for the selected size.
    always_comb begin
        unique case (sz)
            SZ_BYTE: begin mask = DATA_W'(8'hFF);    width = 8;      end
            SZ_WORD: begin mask = DATA_W'(16'hFFFF); width = 16;     end
            default: begin mask = '1;                width = DATA_W; end
        endcase
        sign_bit = DATA_W'(1) << (width - 1);
        am       = a & mask;
        bm       = b & mask;
    end

    // Difference, flags and rotate amount.
    always_comb begin
        diff = (am - bm) & mask;
        zero = (diff == '0);
        neg  = (diff & sign_bit) != '0;
        div0 = (bm == '0);
        sh   = 32'(bm) & (width - 1);
        rot  = ((am << sh) | (am >> (width - sh))) & mask;
    end

    // Result selection by opcode.
    always_comb begin
        unique case (op)
            OP_COPY: y = bm;
            OP_ADD:  y = (am + bm) & mask;
            OP_SUB:  y = diff;
            OP_MUL:  y = (am * bm) & mask;
            OP_DIV:  y = div0 ? mask : (am / bm);
            OP_AND:  y = am & bm;
            OP_OR:   y = am | bm;
            OP_NOT:  y = ~bm & mask;
            OP_ROT:  y = rot;
            default: y = diff;
        endcase
    end

endmodule

// File: rtl/fixfmt_cpu.sv
// Multicycle processor top: phase sequencer, PC, stack pointer, flags and
// the shared memory port. Assumes word-addressed memory answering each
// request with mem_ready; one phase per cycle apart from memory waits.
module fixfmt_cpu
    import fixfmt_pkg::*;
#(
    parameter int              ADDR_W  = 16,
    parameter int              DATA_W  = 32,
    parameter int              NREG    = 16,
    parameter logic [15:0]     SP_INIT = 16'hFFFF,
    localparam int             SEL_W   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_ready,
    output logic              halted,
    output logic              illegal,
    output logic              trap_pulse,
    output logic [15:0]       trap_code,
    output logic              div_err,
    output logic              flag_zero,
    output logic              flag_neg
);

    phase_e            phase;
    instr_t            ir;
    ctrl_t             ctl;
    logic [ADDR_W-1:0] pc, sp, ea_q;
    logic [DATA_W-1:0] mdr, res;
    logic [DATA_W-1:0] rd0, rd1, other, op_a, op_b, alu_y;
    logic              alu_zero, alu_neg, alu_div0;
    logic              rf_we;

    fixfmt_decode u_decode (
        .op(ir.op), .size_code(ir.size), .imm(ir.imm), .dir(ir.dir),
        .mem(ir.mem), .rsel(ir.rsel), .lo_reg(ir.fld[3:0]), .ctl(ctl)
    );

    fixfmt_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ra0(ir.rsel[SEL_W-1:0]), .ra1(ir.fld[SEL_W-1:0]),
        .rd0(rd0), .rd1(rd1),
        .we(rf_we), .wa(ctl.wsel[SEL_W-1:0]), .wd(res)
    );

    // Operand routing: pick the source and swap roles by the direction bit.
    always_comb begin
        if (ir.imm)          other = DATA_W'(ir.fld);
        else if (ctl.src_mem) other = mdr;
        else                  other = rd1;
        op_a = ir.dir ? other : rd0;
        op_b = ir.dir ? rd0   : other;
    end

    fixfmt_alu #(.DATA_W(DATA_W)) u_alu (
        .op(ir.op), .sz(ctl.sz), .a(op_a), .b(op_b),
        .y(alu_y), .zero(alu_zero), .neg(alu_neg), .div0(alu_div0)
    );

    // Memory port and register write strobes from the current phase.
    always_comb begin
        mem_rd    = (phase == PH_FETCH) || ((phase == PH_OPER) && ctl.mem_read);
        mem_wr    = (phase == PH_STORE) && ctl.mem_write;
        if (phase == PH_FETCH)
            mem_addr = pc;
        else if ((ir.op == OP_RET) || (ir.op == OP_JSR))
            mem_addr = sp;
        else
            mem_addr = ea_q;
        mem_wdata = res;
        rf_we     = (phase == PH_STORE) && ctl.reg_write;
        halted    = (phase == PH_HALT);
    end

    // Phase sequencer with PC, stack pointer, flag and trap updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_FETCH;
            ir         <= '0;
            pc         <= '0;
            sp         <= ADDR_W'(SP_INIT);
            ea_q       <= '0;
            mdr        <= '0;
            res        <= '0;
            illegal    <= 1'b0;
            trap_pulse <= 1'b0;
            trap_code  <= '0;
            div_err    <= 1'b0;
            flag_zero  <= 1'b0;
            flag_neg   <= 1'b0;
        end else begin
            trap_pulse <= 1'b0;
            unique case (phase)
                PH_FETCH: begin
                    if (mem_ready) begin
                        ir    <= instr_t'(mem_rdata);
                        phase <= PH_PCUP;
                    end
                end
                PH_PCUP: begin
                    pc    <= pc + 1'b1;
                    phase <= PH_DECODE;
                end
                PH_DECODE: begin
                    ea_q <= ir.ind ? rd1[ADDR_W-1:0] : ADDR_W'(ir.fld);
                    if (ctl.illegal) begin
                        illegal <= 1'b1;
                        phase   <= PH_HALT;
                    end else if (ir.op == OP_HALT) begin
                        phase <= PH_HALT;
                    end else begin
                        phase <= PH_OPER;
                    end
                end
                PH_OPER: begin
                    if (!ctl.mem_read) begin
                        phase <= PH_EXEC;
                    end else if (mem_ready) begin
                        mdr   <= mem_rdata;
                        phase <= PH_EXEC;
                    end
                end
                PH_EXEC: begin
                    res   <= alu_y;
                    phase <= PH_STORE;
                    case (ir.op)
                        OP_CMP: begin
                            flag_zero <= alu_zero;
                            flag_neg  <= alu_neg;
                        end
                        OP_DIV:  if (alu_div0) div_err <= 1'b1;
                        OP_TRAP: begin
                            trap_pulse <= 1'b1;
                            trap_code  <= ir.fld;
                        end
                        OP_LEA:  res <= DATA_W'(ea_q);
                        OP_JMP:  pc  <= ADDR_W'(ir.fld);
                        OP_JSR: begin
                            sp  <= sp - 1'b1;
                            res <= DATA_W'(pc);
                        end
                        OP_RET: begin
                            pc <= mdr[ADDR_W-1:0];
                            sp <= sp + 1'b1;
                        end
                        default: ;
                    endcase
                end
                PH_STORE: begin
                    if (!ctl.mem_write || mem_ready) begin
                        phase <= PH_FETCH;
                        if (ir.op == OP_JSR) pc <= ADDR_W'(ir.fld);
                    end
                end
                PH_HALT: ;
                default: phase <= PH_HALT;
            endcase
        end
    end

    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_request_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_ready) |=>
            ($stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr) && $stable(mem_wdata)));

    assert_fetch_then_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_FETCH) && mem_ready) |=> (phase == PH_PCUP));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PCUP) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

    assert_cmp_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_STORE) && (ir.op == OP_CMP)) |-> (!rf_we && !mem_wr));

    assert_illegal_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

    assert_trap_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |=> !trap_pulse);

    assert_halt_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_rd && !mem_wr));

endmodule

// File: tb/fixfmt_cpu_bench.sv
`timescale 1ns/1ps
module fixfmt_cpu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_rd, mem_wr;
    logic        mem_ready;
    logic        halted, illegal, trap_pulse, div_err, flag_zero, flag_neg;
    logic [15:0] trap_code;

    typedef struct {
        logic [15:0] a;
        logic [31:0] d;
        logic        z, n, e;
    } wr_item_t;

    wr_item_t    exp_q[$];
    logic [15:0] trap_q[$];
    logic [31:0] mem [0:511];
    int          checks = 0;
    int          failures = 0;
    int          wait_n = 0;
    int          lat_sel = 0;
    logic [15:0] req_addr = '0;
    logic        prev_trap = 1'b0;

    always #4 clk = ~clk;

    fixfmt_cpu u_fixfmt_cpu (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready),
        .halted(halted), .illegal(illegal), .trap_pulse(trap_pulse),
        .trap_code(trap_code), .div_err(div_err),
        .flag_zero(flag_zero), .flag_neg(flag_neg)
    );

    function automatic logic [31:0] enc(int op, int sz, bit ind, bit imm, bit dir,
                                        bit mm, int rs, int fld);
        return {op[3:0], sz[3:0], ind, imm, dir, mm, rs[3:0], fld[15:0]};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Driver side of the scoreboard: queue an expected write with flags.
    task automatic expect_wr(logic [15:0] a, logic [31:0] d, bit z, bit n, bit e);
        wr_item_t it;
        it.a = a; it.d = d; it.z = z; it.n = n; it.e = e;
        exp_q.push_back(it);
    endtask

    // Memory model and write monitor: 0/1/2 wait cycles in rotation.
    initial begin
        mem_ready = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (rst_n && halted && (mem_rd || mem_wr))
                check(1'b0, "R13 access while halted", {16'h0, mem_addr}, 32'h0);
            if (rst_n && (mem_rd || mem_wr)) begin
                if (wait_n == 0) req_addr = mem_addr;
                if (wait_n >= lat_sel) begin
                    if (lat_sel != 0)
                        check(mem_addr == req_addr, "R3 address held",
                              {16'h0, mem_addr}, {16'h0, req_addr});
                    mem_ready = 1'b1;
                    if (mem_rd) begin
                        mem_rdata = mem[mem_addr[8:0]];
                    end else begin
                        mem[mem_addr[8:0]] = mem_wdata;
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R7 unexpected write", mem_wdata, 32'h0);
                        end else begin
                            wr_item_t it;
                            it = exp_q.pop_front();
                            check(mem_addr == it.a, "R4 write address",
                                  {16'h0, mem_addr}, {16'h0, it.a});
                            check(mem_wdata == it.d, "R7 write data", mem_wdata, it.d);
                            check({flag_zero, flag_neg, div_err} == {it.z, it.n, it.e},
                                  "R9 flags at write",
                                  {29'h0, flag_zero, flag_neg, div_err},
                                  {29'h0, it.z, it.n, it.e});
                        end
                    end
                    wait_n  = 0;
                    lat_sel = (lat_sel + 1) % 3;
                end else begin
                    mem_ready = 1'b0;
                    wait_n++;
                end
            end else begin
                mem_ready = 1'b0;
                wait_n    = 0;
            end
        end
    end

    // Trap monitor: pops the expected code for each pulse and checks its width.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && trap_pulse) begin
                check(!prev_trap, "R12 pulse width", 32'h1, 32'h0);
                if (trap_q.size() == 0) begin
                    check(1'b0, "R12 unexpected trap", {16'h0, trap_code}, 32'h0);
                end else begin
                    logic [15:0] c;
                    c = trap_q.pop_front();
                    check(trap_code == c, "R12 trap code", {16'h0, trap_code}, {16'h0, c});
                end
            end
            prev_trap = rst_n && trap_pulse;
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 512; i++) mem[i] = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (halted) break;
        end
    endtask

    task automatic print_summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        print_summary();
        $finish;
    end

    initial begin
        // ---------- run 1: main program ----------
        clear_mem();
        mem[9'h180] = 32'h1234_5678;
        mem[0]  = enc(1, 2, 0, 1, 0, 0, 1, 5);        // copy #5 -> r1
        mem[1]  = enc(1, 2, 0, 1, 0, 0, 2, 3);        // copy #3 -> r2
        mem[2]  = enc(8, 2, 0, 0, 0, 0, 1, 2);        // r1 += r2
        mem[3]  = enc(1, 2, 0, 0, 1, 1, 1, 'h100);    // [0x100] := r1
        mem[4]  = enc(9, 2, 0, 0, 0, 0, 2, 1);        // r2 -= r1
        mem[5]  = enc(1, 2, 0, 0, 1, 1, 2, 'h101);
        mem[6]  = enc(8, 0, 0, 1, 0, 0, 2, 'h10);     // byte r2 += #0x10
        mem[7]  = enc(1, 2, 0, 0, 1, 1, 2, 'h102);
        mem[8]  = enc(8, 1, 0, 0, 0, 1, 1, 'h180);    // word r1 += [0x180]
        mem[9]  = enc(1, 2, 0, 0, 1, 1, 1, 'h103);
        mem[10] = enc(8, 2, 0, 0, 1, 1, 2, 'h180);    // [0x180] += r2
        mem[11] = enc(2, 2, 0, 0, 0, 0, 3, 'h181);    // r3 := addr 0x181
        mem[12] = enc(1, 2, 1, 0, 1, 1, 1, 3);        // [r3] := r1
        mem[13] = enc(11, 2, 0, 1, 0, 0, 1, 0);       // r1 /= #0
        mem[14] = enc(1, 2, 0, 0, 1, 1, 1, 'h104);
        mem[15] = enc(3, 2, 0, 0, 0, 0, 0, 'h77);     // trap 0x77
        mem[16] = enc(5, 2, 0, 1, 0, 0, 2, 'h0B);     // cmp r2, #0x0B
        mem[17] = enc(1, 2, 0, 1, 0, 0, 5, 'h81);
        mem[18] = enc(15, 0, 0, 1, 0, 0, 5, 1);       // byte rotate r5 by 1
        mem[19] = enc(1, 2, 0, 0, 1, 1, 5, 'h105);
        mem[20] = enc(1, 2, 0, 1, 0, 0, 6, 'h300);
        mem[21] = enc(10, 1, 0, 1, 0, 0, 6, 'h100);   // word r6 *= #0x100
        mem[22] = enc(1, 2, 0, 0, 1, 1, 6, 'h106);
        mem[23] = enc(5, 1, 0, 1, 0, 0, 6, 1);        // word cmp r6, #1
        mem[24] = enc(1, 2, 0, 1, 0, 0, 7, 'hF0F0);
        mem[25] = enc(12, 2, 0, 1, 0, 0, 7, 'h0FF0);
        mem[26] = enc(13, 2, 0, 1, 0, 0, 7, 3);
        mem[27] = enc(14, 0, 0, 0, 0, 0, 8, 7);       // byte r8 := ~r7
        mem[28] = enc(1, 2, 0, 0, 1, 1, 7, 'h107);
        mem[29] = enc(1, 2, 0, 0, 1, 1, 8, 'h108);
        mem[30] = enc(6, 2, 0, 0, 0, 0, 0, 'h40);     // call 0x40
        mem[31] = enc(4, 2, 0, 0, 0, 0, 0, 'h50);     // jump 0x50
        mem[32] = enc(1, 2, 0, 0, 1, 1, 1, 'h10A);    // skipped
        mem[9'h40] = enc(1, 2, 0, 1, 0, 0, 9, 'h99);
        mem[9'h41] = enc(1, 2, 0, 0, 1, 1, 9, 'h109);
        mem[9'h42] = enc(7, 2, 0, 0, 0, 0, 0, 0);     // return
        mem[9'h50] = enc(6, 2, 0, 0, 0, 0, 0, 'h60);  // call 0x60
        mem[9'h51] = enc(0, 2, 0, 0, 0, 0, 0, 0);     // halt
        mem[9'h60] = enc(7, 2, 0, 0, 0, 0, 0, 0);

        expect_wr(16'h0100, 32'h0000_0008, 0, 0, 0);  // R7 add, R5 reg dest
        expect_wr(16'h0101, 32'hFFFF_FFFB, 0, 0, 0);  // R7 sub
        expect_wr(16'h0102, 32'h0000_000B, 0, 0, 0);  // R6 byte wrap
        expect_wr(16'h0103, 32'h0000_5680, 0, 0, 0);  // R4 direct memory source
        expect_wr(16'h0180, 32'h1234_5683, 0, 0, 0);  // R5 memory destination
        expect_wr(16'h0181, 32'h0000_5680, 0, 0, 0);  // R4 indirect, R10 address
        expect_wr(16'h0104, 32'hFFFF_FFFF, 0, 0, 1);  // R8 divide by zero
        trap_q.push_back(16'h0077);                   // R12
        expect_wr(16'h0105, 32'h0000_0003, 1, 0, 1);  // R7 rotate, R9 zero flag
        expect_wr(16'h0106, 32'h0000_0000, 1, 0, 1);  // R7 mult low bits
        expect_wr(16'h0107, 32'h0000_00F3, 0, 1, 1);  // R7 and/or, R9 neg flag
        expect_wr(16'h0108, 32'h0000_000C, 0, 1, 1);  // R7 not
        expect_wr(16'hFFFE, 32'h0000_001F, 0, 1, 1);  // R2 and R11 saved next PC
        expect_wr(16'h0109, 32'h0000_0099, 0, 1, 1);
        expect_wr(16'hFFFE, 32'h0000_0051, 0, 1, 1);  // R11 stack pointer restored

        do_reset();
        #1;
        // R1 reset state
        check(mem_rd && (mem_addr == 16'h0), "R1 first fetch",
              {15'h0, mem_rd, mem_addr}, 32'h0001_0000);
        check({halted, illegal, trap_pulse, div_err, flag_zero, flag_neg} == 6'b0,
              "R1 status clear",
              {26'h0, halted, illegal, trap_pulse, div_err, flag_zero, flag_neg}, 32'h0);

        wait_halt();
        check(halted && !illegal, "R13 halted after halt",
              {30'h0, halted, illegal}, 32'h2);
        repeat (20) @(negedge clk);
        check(halted, "R13 halt holds", {31'h0, halted}, 32'h1);
        check(exp_q.size() == 0, "R11 all writes seen", exp_q.size(), 32'h0);
        check(trap_q.size() == 0, "R12 trap seen", trap_q.size(), 32'h0);

        // ---------- run 2: undefined size code ----------
        clear_mem();
        mem[0] = enc(1, 3, 0, 1, 0, 0, 1, 5);
        mem[1] = enc(1, 2, 0, 0, 1, 1, 1, 'h100);
        do_reset();
        wait_halt();
        repeat (5) @(negedge clk);
        check(illegal && halted, "R6 bad size halts",
              {30'h0, illegal, halted}, 32'h3);
        check(mem[9'h100] == 32'h0, "R6 no write after illegal", mem[9'h100], 32'h0);

        // ---------- run 3: immediate with register as source ----------
        clear_mem();
        mem[0] = enc(1, 2, 0, 1, 1, 0, 1, 5);
        mem[1] = enc(1, 2, 0, 0, 1, 1, 1, 'h100);
        do_reset();
        #1;
        check(!illegal && !halted, "R1 reset clears illegal",
              {30'h0, illegal, halted}, 32'h0);
        wait_halt();
        repeat (5) @(negedge clk);
        check(illegal && halted, "R5 immediate destination illegal",
              {30'h0, illegal, halted}, 32'h3);
        check(exp_q.size() == 0, "R5 no stray write", exp_q.size(), 32'h0);

        print_summary();
        $finish;
    end

endmodule